// File: doc/BRIEF.md
# Masked Multi-Address I2C Target Address Matcher

This block watches the receive side of an I2C target and decides whether the first byte after a START condition is meant for it. It shifts in eight bits on rising SCL edges, most significant bit first. The upper seven bits form the address and the eighth is the read/write bit. The address is compared against a configurable number of own-address slots; the default is four. Each slot has its own 7-bit address, its own per-bit don't-care mask and its own general-call enable. When at least one slot accepts the address, the block can acknowledge it on the ninth SCL clock.

SDA and SCL arrive already synchronised and reduced to one-cycle event pulses: SCL rising, SCL falling, START detected and STOP detected. The block returns the SDA pull-down request, a level that marks the target as addressed, the index of the slot that won, a general-call flag and the received read/write bit. An acknowledge-enable input is captured at each START and decides whether a match is acknowledged. A master-mode input and a software stop request both force the matcher back to the not-addressed state.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: After reset, sda_drive_low, match_valid, match_slot, match_gc and match_rw are all 0.
- R2: After start_det, the block samples sda_in on each of the next eight scl_rise pulses. The first sample is address bit 6 and the eighth sample is the R/W bit, which is reported on match_rw.
- R3: Slot i holds its address in own_addr_cfg[8i+7:8i+1] and its mask in addr_mask_cfg[7i+6:7i]. The slot matches a non-general-call address when every received bit whose mask bit is 0 equals the corresponding address bit. A mask bit of 1 makes that address bit a don't-care.
- R4: A received address of 0000000 with R/W = 0 is a general call. It matches only slots whose general-call enable own_addr_cfg[8i] is 1, and a reported match then has match_gc = 1.
- R5: When several slots match, match_slot reports the lowest-numbered matching slot.
- R6: With ack_en = 1 at START and a match, sda_drive_low and match_valid become 1 one cycle after the scl_fall pulse that ends the eighth bit. sda_drive_low returns to 0 one cycle after the next scl_fall pulse (the end of the ninth clock), while match_valid stays at 1.
- R7: With ack_en = 0 at START, no acknowledge is driven and match_valid stays 0, even for an address that matches.
- R8: While master_mode is 1, the address slots have no effect: match_valid and sda_drive_low stay 0.
- R9: A stop_req pulse returns the block to the not-addressed state, with match_valid and sda_drive_low both 0 on the next cycle.
- R10: A start_det pulse restarts address collection from the first bit, even in the middle of a byte. A stop_det pulse returns the block to idle, so bits that follow it are ignored until the next START.
- R11: An address that matches no slot is not acknowledged: sda_drive_low and match_valid stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | Controller is acting as bus master; target matching is disabled |
| stop_req | input | 1 | Software stop request; returns the block to not-addressed |
| ack_en | input | 1 | Acknowledge enable, captured at START |
| own_addr_cfg | input | NSLOT*8 | Per slot: address in bits 7:1, general-call enable in bit 0 |
| addr_mask_cfg | input | NSLOT*7 | Per slot: 7-bit don't-care mask |
| start_det | input | 1 | One-cycle pulse marking a START or repeated START |
| stop_det | input | 1 | One-cycle pulse marking a STOP |
| scl_rise | input | 1 | One-cycle pulse on a rising SCL edge |
| scl_fall | input | 1 | One-cycle pulse on a falling SCL edge |
| sda_in | input | 1 | Synchronised SDA level |
| sda_drive_low | output | 1 | 1 = pull SDA low (acknowledge) |
| match_valid | output | 1 | Target addressed and acknowledged |
| match_slot | output | clog2(NSLOT) | Index of the winning slot |
| match_gc | output | 1 | The match was a general call |
| match_rw | output | 1 | Received R/W bit |

## Verification
Every result is registered. The match outputs and the acknowledge request change exactly one clock after the scl_fall pulse that ends the eighth bit. The release of SDA follows one clock after the scl_fall pulse that ends the ninth bit, and stop_req, stop_det and master_mode take effect one clock after they are seen. The bench drives each event pulse for one cycle between falling clock edges. It samples the outputs on the falling edge that ends the pulse, which is the first point where the registered value is visible. All 256 possible first bytes are swept against an overlapping slot configuration, and each expected slot, general-call flag and acknowledge is computed from the mask arithmetic.

// File: rtl/i2c_tam_pkg.sv
package i2c_tam_pkg;
   typedef enum logic [1:0] {
      TAM_IDLE = 2'd0,
      TAM_ADDR = 2'd1,
      TAM_ACK  = 2'd2,
      TAM_HELD = 2'd3
   } tam_state_e;
endpackage

// File: rtl/tam_bit_collector.sv
module tam_bit_collector #(
   parameter int BITS = 8,
   localparam int CW = $clog2(BITS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            shift_en,
   input  logic            bit_in,
   output logic [BITS-1:0] data,
   output logic            full
);
   logic [CW-1:0] cnt_q;

   if (BITS < 2) begin : g_bad_bits
      $error("tam_bit_collector: BITS must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         data  <= '0;
      end else if (clear) begin
         cnt_q <= '0;
         data  <= '0;
      end else if (shift_en && !full) begin
         cnt_q <= cnt_q + 1'b1;
         data  <= {data[BITS-2:0], bit_in};
      end
   end

   assign full = (cnt_q == CW'(BITS));
endmodule

// File: rtl/tam_slot_cmp.sv
module tam_slot_cmp #(
   parameter int AW = 7
) (
   input  logic [AW-1:0] rx_addr,
   input  logic          rx_rw,
   input  logic [AW-1:0] own_addr,
   input  logic [AW-1:0] dont_care,
   input  logic          gc_en,
   output logic          hit
);
   logic          is_gc;
   logic [AW-1:0] diff;

   always_comb begin
      is_gc = (rx_addr == '0) && !rx_rw;
      diff  = (rx_addr ^ own_addr) & ~dont_care;
      hit   = is_gc ? gc_en : (diff == '0);
   end
endmodule

// File: rtl/tam_prio_pick.sv
module tam_prio_pick #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
   import i2c_tam_pkg::*;
#(
   parameter int NSLOT = 4,
   parameter int AW    = 7,
   localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  master_mode,
   input  logic                  stop_req,
   input  logic                  ack_en,
   input  logic [NSLOT*(AW+1)-1:0] own_addr_cfg,
   input  logic [NSLOT*AW-1:0]   addr_mask_cfg,
   input  logic                  start_det,
   input  logic                  stop_det,
   input  logic                  scl_rise,
   input  logic                  scl_fall,
   input  logic                  sda_in,
   output logic                  sda_drive_low,
   output logic                  match_valid,
   output logic [IW-1:0]         match_slot,
   output logic                  match_gc,
   output logic                  match_rw
);
   localparam int BYTE_W = AW + 1;

   if (NSLOT < 1 || NSLOT > 16) begin : g_bad_nslot
      $error("i2c_tgt_addr_match: NSLOT must be 1..16");
   end
   if (AW < 2 || AW > 10) begin : g_bad_aw
      $error("i2c_tgt_addr_match: AW must be 2..10");
   end

   tam_state_e        state_q;
   logic              ack_q;
   logic [BYTE_W-1:0] rx_byte;
   logic              rx_full;
   logic [AW-1:0]     rx_addr;
   logic              rx_rw;
   logic              rx_is_gc;
   logic [NSLOT-1:0]  slot_hit;
   logic              any_hit;
   logic [IW-1:0]     win_idx;
   logic              abort;
   logic              shift_en;

   assign rx_addr  = rx_byte[BYTE_W-1:1];
   assign rx_rw    = rx_byte[0];
   assign rx_is_gc = (rx_addr == '0) && !rx_rw;
   assign abort    = master_mode || stop_req || stop_det;
   assign shift_en = scl_rise && (state_q == TAM_ADDR) && !abort && !start_det;

   tam_bit_collector #(.BITS(BYTE_W)) u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start_det),
      .shift_en (shift_en),
      .bit_in   (sda_in),
      .data     (rx_byte),
      .full     (rx_full)
   );

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      tam_slot_cmp #(.AW(AW)) u_cmp (
         .rx_addr   (rx_addr),
         .rx_rw     (rx_rw),
         .own_addr  (own_addr_cfg[s*BYTE_W+1 +: AW]),
         .dont_care (addr_mask_cfg[s*AW +: AW]),
         .gc_en     (own_addr_cfg[s*BYTE_W]),
         .hit       (slot_hit[s])
      );
   end

   tam_prio_pick #(.N(NSLOT)) u_pick (
      .req (slot_hit),
      .any (any_hit),
      .idx (win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= TAM_IDLE;
         ack_q         <= 1'b0;
         sda_drive_low <= 1'b0;
         match_valid   <= 1'b0;
         match_slot    <= '0;
         match_gc      <= 1'b0;
         match_rw      <= 1'b0;
      end else if (abort) begin
         state_q       <= TAM_IDLE;
         sda_drive_low <= 1'b0;
         match_valid   <= 1'b0;
         match_slot    <= '0;
         match_gc      <= 1'b0;
         match_rw      <= 1'b0;
      end else if (start_det) begin
         state_q       <= TAM_ADDR;
         ack_q         <= ack_en;
         sda_drive_low <= 1'b0;
         match_valid   <= 1'b0;
         match_slot    <= '0;
         match_gc      <= 1'b0;
         match_rw      <= 1'b0;
      end else begin
         unique case (state_q)
            TAM_ADDR: begin
               if (scl_fall && rx_full) begin
                  if (any_hit && ack_q) begin
                     state_q       <= TAM_ACK;
                     sda_drive_low <= 1'b1;
                     match_valid   <= 1'b1;
                     match_slot    <= win_idx;
                     match_gc      <= rx_is_gc;
                     match_rw      <= rx_rw;
                  end else begin
                     state_q <= TAM_IDLE;
                  end
               end
            end
            TAM_ACK: begin
               if (scl_fall) begin
                  sda_drive_low <= 1'b0;
                  state_q       <= TAM_HELD;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_tgt_addr_match_chk.sv
module i2c_tgt_addr_match_chk #(
   parameter int NSLOT = 4,
   localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          master_mode,
   input logic          stop_req,
   input logic          start_det,
   input logic          stop_det,
   input logic          scl_fall,
   input logic          sda_drive_low,
   input logic          match_valid,
   input logic [IW-1:0] match_slot,
   input logic          match_gc,
   input logic          match_rw
);
   // R6
   ack_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_drive_low |-> match_valid);

   // R6
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_drive_low && scl_fall) |=> !sda_drive_low);

   // R6
   match_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_valid) |-> $past(scl_fall));

   // R8
   master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      master_mode |=> (!match_valid && !sda_drive_low));

   // R9
   stop_req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> (!match_valid && !sda_drive_low));

   // R10
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!match_valid && !sda_drive_low));

   // R10
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !match_valid);

   // R4
   gc_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_gc |-> (!match_rw && match_valid));

   // R5
   slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |-> (int'(match_slot) < NSLOT));
endmodule

bind i2c_tgt_addr_match i2c_tgt_addr_match_chk #(.NSLOT(NSLOT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .master_mode   (master_mode),
   .stop_req      (stop_req),
   .start_det     (start_det),
   .stop_det      (stop_det),
   .scl_fall      (scl_fall),
   .sda_drive_low (sda_drive_low),
   .match_valid   (match_valid),
   .match_slot    (match_slot),
   .match_gc      (match_gc),
   .match_rw      (match_rw)
);

// File: tb/i2c_tgt_addr_match_test.sv
module i2c_tgt_addr_match_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_mode = 1'b0;
   logic        stop_req = 1'b0;
   logic        ack_en = 1'b0;
   logic [31:0] own_addr_cfg;
   logic [27:0] addr_mask_cfg;
   logic        start_det = 1'b0;
   logic        stop_det = 1'b0;
   logic        scl_rise = 1'b0;
   logic        scl_fall = 1'b0;
   logic        sda_in = 1'b1;
   logic        sda_drive_low;
   logic        match_valid;
   logic [1:0]  match_slot;
   logic        match_gc;
   logic        match_rw;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [6:0] cfg_addr [4];
   logic [6:0] cfg_mask [4];
   logic       cfg_gc   [4];

   always #5 clk = ~clk;

   i2c_tgt_addr_match uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .master_mode   (master_mode),
      .stop_req      (stop_req),
      .ack_en        (ack_en),
      .own_addr_cfg  (own_addr_cfg),
      .addr_mask_cfg (addr_mask_cfg),
      .start_det     (start_det),
      .stop_det      (stop_det),
      .scl_rise      (scl_rise),
      .scl_fall      (scl_fall),
      .sda_in        (sda_in),
      .sda_drive_low (sda_drive_low),
      .match_valid   (match_valid),
      .match_slot    (match_slot),
      .match_gc      (match_gc),
      .match_rw      (match_rw)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic apply_cfg();
      for (int s = 0; s < 4; s++) begin
         own_addr_cfg[s*8 +: 8]  = {cfg_addr[s], cfg_gc[s]};
         addr_mask_cfg[s*7 +: 7] = cfg_mask[s];
      end
   endtask

   task automatic pulse_start();
      start_det = 1'b1; tick(); start_det = 1'b0; tick();
   endtask

   task automatic pulse_stop();
      stop_det = 1'b1; tick(); stop_det = 1'b0; tick();
   endtask

   task automatic clock_bit(input logic b);
      sda_in = b;
      scl_rise = 1'b1; tick(); scl_rise = 1'b0; tick();
      scl_fall = 1'b1; tick(); scl_fall = 1'b0;
   endtask

   // Expected outcome from the masking and priority rules (R3, R4, R5)
   task automatic model(input logic [7:0] b, output logic hit, output int slot, output logic gc);
      logic g;
      g = (b == 8'h00);
      hit = 1'b0; slot = 0; gc = g;
      for (int s = 3; s >= 0; s--) begin
         logic h;
         if (g) h = cfg_gc[s];
         else   h = (((b[7:1] ^ cfg_addr[s]) & ~cfg_mask[s]) == 7'd0);
         if (h) begin hit = 1'b1; slot = s; end
      end
   endtask

   task automatic run_addr(input logic [7:0] b, input logic aen, input logic blocked, input string tag);
      logic hit, gc, exp_ack;
      int slot;
      model(b, hit, slot, gc);
      exp_ack = hit && aen && !blocked;
      ack_en = aen;
      pulse_start();
      for (int i = 7; i >= 0; i--) clock_bit(b[i]);
      tick();
      // outputs due one cycle after the eighth scl_fall pulse
      check(exp_ack ? "R6" : tag, "ack", int'(sda_drive_low), int'(exp_ack));
      check(exp_ack ? "R3" : tag, "valid", int'(match_valid), int'(exp_ack));
      if (exp_ack) begin
         check("R5", "slot", int'(match_slot), slot);
         check("R4", "gc", int'(match_gc), int'(gc));
         check("R2", "rw", int'(match_rw), int'(b[0]));
      end
      clock_bit(1'b1);
      tick();
      check("R6", "release", int'(sda_drive_low), 0);
      check("R6", "held", int'(match_valid), int'(exp_ack));
      pulse_stop();
      check("R10", "stop idle", int'(match_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cfg_addr[0] = 7'h50; cfg_mask[0] = 7'h03; cfg_gc[0] = 1'b0;
      cfg_addr[1] = 7'h52; cfg_mask[1] = 7'h00; cfg_gc[1] = 1'b1;
      cfg_addr[2] = 7'h10; cfg_mask[2] = 7'h70; cfg_gc[2] = 1'b0;
      cfg_addr[3] = 7'h1F; cfg_mask[3] = 7'h0F; cfg_gc[3] = 1'b1;
      apply_cfg();
      tick(); tick();
      // R1
      check("R1", "reset ack", int'(sda_drive_low), 0);
      check("R1", "reset valid", int'(match_valid), 0);
      check("R1", "reset slot", int'(match_slot), 0);
      check("R1", "reset gc", int'(match_gc), 0);
      check("R1", "reset rw", int'(match_rw), 0);
      rst_n = 1'b1;
      tick();

      // Full sweep of the first byte (R2, R3, R4, R5, R6, R11)
      for (int b = 0; b < 256; b++) run_addr(8'(b), 1'b1, 1'b0, "R11");

      // R7: acknowledge disabled
      for (int b = 0; b < 256; b += 9) run_addr(8'(b), 1'b0, 1'b0, "R7");

      // R4: general call with every enable cleared
      cfg_gc[1] = 1'b0; cfg_gc[3] = 1'b0; apply_cfg();
      run_addr(8'h00, 1'b1, 1'b0, "R4");
      run_addr(8'h01, 1'b1, 1'b0, "R4");
      cfg_gc[1] = 1'b1; cfg_gc[3] = 1'b1; apply_cfg();

      // R8: master mode blocks matching
      master_mode = 1'b1;
      run_addr(8'hA0, 1'b1, 1'b1, "R8");
      run_addr(8'h00, 1'b1, 1'b1, "R8");
      master_mode = 1'b0;

      // R9: software stop request drops the addressed state
      ack_en = 1'b1;
      pulse_start();
      for (int i = 7; i >= 0; i--) clock_bit(logic'((8'hA4 >> i) & 1));
      tick();
      check("R9", "addressed before stop_req", int'(match_valid), 1);
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      check("R9", "stop_req valid", int'(match_valid), 0);
      check("R9", "stop_req ack", int'(sda_drive_low), 0);
      pulse_stop();

      // R10: repeated START mid-byte restarts collection
      pulse_start();
      clock_bit(1'b0); clock_bit(1'b1); clock_bit(1'b1);
      tick();
      pulse_start();
      for (int i = 7; i >= 0; i--) clock_bit(logic'((8'hA5 >> i) & 1));
      tick();
      check("R10", "restart valid", int'(match_valid), 1);
      check("R10", "restart slot", int'(match_slot), 0);
      check("R10", "restart rw", int'(match_rw), 1);
      pulse_stop();

      // R10: STOP mid-address, following bits ignored
      pulse_start();
      for (int i = 7; i >= 4; i--) clock_bit(logic'((8'hA4 >> i) & 1));
      tick();
      pulse_stop();
      for (int i = 7; i >= 0; i--) clock_bit(logic'((8'hA4 >> i) & 1));
      tick();
      check("R10", "after stop ack", int'(sda_drive_low), 0);
      check("R10", "after stop valid", int'(match_valid), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule